// File: doc/BRIEF.md
# Wide Program Counter Jump Unit

This unit holds the program counter of a small controller whose data registers are only 8 bits wide, while its program counter is 22 bits wide and counts 16-bit instruction words. The counter is wider than any data register, so each jump type builds its target from a different source. An indirect jump takes a 16-bit pointer from a pair of 8-bit registers and clears the upper bits. An extended indirect jump takes the same pointer and fills the upper bits from an extension register. An absolute jump carries its full target across two instruction words.

Each cycle in which `step` is high, the decoder presents one instruction word, already classified into a jump kind. The unit registers the next program counter. When the instruction needs a second word, it raises `fetch_wide` and holds the counter until that word arrives. The second word then either supplies the low 16 bits of an absolute target or completes an ordinary two-word instruction, which advances the counter by two.

Top module: `pc_jump_unit`

## Requirements
- R1: While `rst` is high at a rising edge, `pc` becomes 0 and `fetch_wide` becomes 0.
- R2: A first word with kind 0 (sequential), or with one of the unused kinds 5, 6 and 7, advances `pc` by 1. The increment wraps from 0x3FFFFF to 0.
- R3: While `step` is low, `pc` and `fetch_wide` keep their values whatever the other inputs carry.
- R4: A first word with kind 1 (indirect) loads `pc` with {6'b0, `ptr_hi`, `ptr_lo`}. `ptr_hi` is the high byte.
- R5: A first word with kind 2 (extended indirect) loads `pc` with {`ext_reg`[5:0], `ptr_hi`, `ptr_lo`}. `ext_reg`[7:6] has no effect.
- R6: A first word with kind 3 (absolute) leaves `pc` unchanged and sets `fetch_wide`. The upper 6 target bits are taken from `imm_word`[5:0], and `imm_word`[15:6] has no effect.
- R7: The word that follows an absolute first word loads `pc` with {saved 6 bits, `imm_word`} and clears `fetch_wide`. `jmp_kind` is ignored on that word.
- R8: A first word with kind 4 (two-word, no jump) leaves `pc` unchanged and sets `fetch_wide`. Its second word advances `pc` by 2, modulo 2^22, and clears `fetch_wide`.
- R9: While `fetch_wide` is high, cycles with `step` low do not consume the pending second word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| step | input | 1 | An instruction word is present this cycle |
| jmp_kind | input | 3 | Decoded kind of a first word |
| ptr_hi | input | 8 | High byte of the pointer pair |
| ptr_lo | input | 8 | Low byte of the pointer pair |
| ext_reg | input | 8 | Extension register; low 6 bits used |
| imm_word | input | 16 | Current instruction word |
| pc | output | 22 | Registered program counter, in words |
| fetch_wide | output | 1 | A second instruction word is awaited |

## Verification
Two events can fall in the same cycle: the second word of a pending two-word instruction, and a new jump kind that the decoder drives onto `jmp_kind`. The bench forces this case by driving an indirect kind, with live pointer bytes, alongside the second word of an absolute jump. It judges the result by checking that `pc` equals the assembled absolute target and not the pointer. The +2 advance is also driven across the top of the address range, and stalls are inserted in the middle of a pending two-word instruction, with `pc` and `fetch_wide` compared after every edge.

// File: rtl/pcj_pkg.sv
package pcj_pkg;
  typedef enum logic [2:0] {
    JK_SEQ  = 3'd0,
    JK_IND  = 3'd1,
    JK_EXT  = 3'd2,
    JK_ABS  = 3'd3,
    JK_SEQ2 = 3'd4
  } jkind_e;
endpackage

// File: rtl/pcj_target_mux.sv
// Builds the register-sourced jump target: pointer pair in the low bits,
// extension bits or zeros in the upper bits.
module pcj_target_mux #(
  parameter int PC_W  = 22,
  parameter int REG_W = 8
) (
  input  logic             sel_ext,
  input  logic [REG_W-1:0] ptr_hi,
  input  logic [REG_W-1:0] ptr_lo,
  input  logic [REG_W-1:0] ext_reg,
  output logic [PC_W-1:0]  tgt
);
  localparam int PTR_W = 2 * REG_W;
  localparam int EXT_W = PC_W - PTR_W;

  logic [PTR_W-1:0] ptr;
  assign ptr = {ptr_hi, ptr_lo};

  generate
    if (EXT_W > 0) begin : g_upper
      logic [EXT_W-1:0] ext_bits;
      assign ext_bits = sel_ext ? EXT_W'(ext_reg) : '0;
      assign tgt = {ext_bits, ptr};
    end else begin : g_flat
      assign tgt = PC_W'(ptr);
    end
  endgenerate
endmodule

// File: rtl/pcj_seq_adder.sv
// Sequential advance by one or two words, wrapping at the counter width.
module pcj_seq_adder #(
  parameter int PC_W = 22
) (
  input  logic [PC_W-1:0] pc_cur,
  input  logic            by_two,
  output logic [PC_W-1:0] pc_inc
);
  logic [PC_W-1:0] delta;
  assign delta  = by_two ? PC_W'(2) : PC_W'(1);
  assign pc_inc = pc_cur + delta;
endmodule

// File: rtl/pcj_wide_latch.sv
// Tracks a two-word instruction between its first and second word and
// keeps the upper target bits carried by an absolute first word.
module pcj_wide_latch #(
  parameter int HI_W = 6
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            start,
  input  logic            start_abs,
  input  logic            finish,
  input  logic [HI_W-1:0] hi_in,
  output logic            busy,
  output logic            busy_abs,
  output logic [HI_W-1:0] hi_q
);
  always_ff @(posedge clk) begin
    if (rst) begin
      busy     <= 1'b0;
      busy_abs <= 1'b0;
      hi_q     <= '0;
    end else if (start) begin
      busy     <= 1'b1;
      busy_abs <= start_abs;
      hi_q     <= hi_in;
    end else if (finish) begin
      busy     <= 1'b0;
      busy_abs <= 1'b0;
    end
  end
endmodule

// File: rtl/pc_jump_unit.sv
module pc_jump_unit #(
  parameter int PC_W   = 22,
  parameter int REG_W  = 8,
  parameter int WORD_W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              step,
  input  logic [2:0]        jmp_kind,
  input  logic [REG_W-1:0]  ptr_hi,
  input  logic [REG_W-1:0]  ptr_lo,
  input  logic [REG_W-1:0]  ext_reg,
  input  logic [WORD_W-1:0] imm_word,
  output logic [PC_W-1:0]   pc,
  output logic              fetch_wide
);
  import pcj_pkg::*;

  localparam int HI_W = PC_W - WORD_W;

  jkind_e          kind;
  logic            busy, busy_abs;
  logic [HI_W-1:0] hi_q;
  logic            first_ok, finish, start, start_abs;
  logic [PC_W-1:0] reg_tgt, pc_inc, pc_nxt, abs_tgt;

  assign kind      = jkind_e'(jmp_kind);
  assign first_ok  = step && !busy;
  assign finish    = step && busy;
  assign start_abs = (kind == JK_ABS);
  assign start     = first_ok && (start_abs || kind == JK_SEQ2);

  pcj_target_mux #(.PC_W(PC_W), .REG_W(REG_W)) u_tmux (
    .sel_ext (kind == JK_EXT),
    .ptr_hi  (ptr_hi),
    .ptr_lo  (ptr_lo),
    .ext_reg (ext_reg),
    .tgt     (reg_tgt)
  );

  pcj_seq_adder #(.PC_W(PC_W)) u_add (
    .pc_cur (pc),
    .by_two (busy),
    .pc_inc (pc_inc)
  );

  pcj_wide_latch #(.HI_W(HI_W)) u_wide (
    .clk       (clk),
    .rst       (rst),
    .start     (start),
    .start_abs (start_abs),
    .finish    (finish),
    .hi_in     (imm_word[HI_W-1:0]),
    .busy      (busy),
    .busy_abs  (busy_abs),
    .hi_q      (hi_q)
  );

  assign abs_tgt = {hi_q, imm_word};

  always_comb begin
    pc_nxt = pc;
    if (finish) begin
      pc_nxt = busy_abs ? abs_tgt : pc_inc;
    end else if (first_ok) begin
      unique case (kind)
        JK_IND, JK_EXT:  pc_nxt = reg_tgt;
        JK_ABS, JK_SEQ2: pc_nxt = pc;
        default:         pc_nxt = pc_inc;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) pc <= '0;
    else     pc <= pc_nxt;
  end

  assign fetch_wide = busy;
endmodule

// File: rtl/pcj_checker.sv
module pcj_checker #(
  parameter int PC_W  = 22,
  parameter int REG_W = 8
) (
  input logic             clk,
  input logic             rst,
  input logic             step,
  input logic [2:0]       jmp_kind,
  input logic [REG_W-1:0] ptr_hi,
  input logic [REG_W-1:0] ptr_lo,
  input logic [PC_W-1:0]  pc,
  input logic             fetch_wide
);
  localparam int UP_W = PC_W - 2 * REG_W;

  logic rst_q = 1'b0;
  always_ff @(posedge clk) rst_q <= rst;

  // R1
  always_ff @(posedge clk) begin
    if (rst_q) begin
      reset_clear_chk: assert (pc == '0 && !fetch_wide);
    end
  end

  // R2
  seq_step_chk: assert property (@(posedge clk) disable iff (rst)
    (step && !fetch_wide && jmp_kind == 3'd0) |=> pc == PC_W'($past(pc) + 1'b1));

  // R3
  stall_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !step |=> ($stable(pc) && $stable(fetch_wide)));

  // R4
  ind_load_chk: assert property (@(posedge clk) disable iff (rst)
    (step && !fetch_wide && jmp_kind == 3'd1) |=>
      pc == {{UP_W{1'b0}}, $past(ptr_hi), $past(ptr_lo)});

  // R6
  abs_first_chk: assert property (@(posedge clk) disable iff (rst)
    (step && !fetch_wide && jmp_kind == 3'd3) |=> (fetch_wide && $stable(pc)));

  // R7
  second_word_chk: assert property (@(posedge clk) disable iff (rst)
    (step && fetch_wide) |=> !fetch_wide);
endmodule

bind pc_jump_unit pcj_checker #(.PC_W(PC_W), .REG_W(REG_W)) u_chk (
  .clk        (clk),
  .rst        (rst),
  .step       (step),
  .jmp_kind   (jmp_kind),
  .ptr_hi     (ptr_hi),
  .ptr_lo     (ptr_lo),
  .pc         (pc),
  .fetch_wide (fetch_wide)
);

// File: tb/test_pc_jump_unit.sv
module test_pc_jump_unit;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        step = 1'b0;
  logic [2:0]  jmp_kind = '0;
  logic [7:0]  ptr_hi = '0, ptr_lo = '0, ext_reg = '0;
  logic [15:0] imm_word = '0;
  logic [21:0] pc;
  logic        fetch_wide;

  int errors = 0;
  int checks = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  pc_jump_unit i_pc_jump_unit (
    .clk(clk), .rst(rst), .step(step), .jmp_kind(jmp_kind),
    .ptr_hi(ptr_hi), .ptr_lo(ptr_lo), .ext_reg(ext_reg),
    .imm_word(imm_word), .pc(pc), .fetch_wide(fetch_wide)
  );

  typedef struct packed {
    logic [3:0]  req;
    logic [2:0]  kind;
    logic [7:0]  hi;
    logic [7:0]  lo;
    logic [7:0]  ext;
    logic [15:0] imm;
    logic [21:0] exp_pc;
    logic        exp_w;
  } vec_t;

  localparam int NV = 16;
  localparam vec_t VECS [NV] = '{
    '{4'd2, 3'd0, 8'h00, 8'h00, 8'h00, 16'h0000, 22'h000001, 1'b0}, // R2
    '{4'd2, 3'd0, 8'h00, 8'h00, 8'h00, 16'h0000, 22'h000002, 1'b0}, // R2
    '{4'd4, 3'd1, 8'h12, 8'h34, 8'h3F, 16'h0000, 22'h001234, 1'b0}, // R4 ext ignored
    '{4'd5, 3'd2, 8'hAB, 8'hCD, 8'hC5, 16'h0000, 22'h05ABCD, 1'b0}, // R5 top bits dropped
    '{4'd2, 3'd0, 8'h00, 8'h00, 8'h00, 16'h0000, 22'h05ABCE, 1'b0}, // R2
    '{4'd2, 3'd6, 8'h11, 8'h22, 8'h00, 16'h0000, 22'h05ABCF, 1'b0}, // R2 unused kind
    '{4'd6, 3'd3, 8'h00, 8'h00, 8'h00, 16'hFFE3, 22'h05ABCF, 1'b1}, // R6
    '{4'd7, 3'd1, 8'h99, 8'h88, 8'h00, 16'h4567, 22'h234567, 1'b0}, // R7 kind ignored
    '{4'd8, 3'd4, 8'h00, 8'h00, 8'h00, 16'h0000, 22'h234567, 1'b1}, // R8
    '{4'd8, 3'd0, 8'h00, 8'h00, 8'h00, 16'h0000, 22'h234569, 1'b0}, // R8
    '{4'd4, 3'd1, 8'hFF, 8'hFF, 8'hFF, 16'h0000, 22'h00FFFF, 1'b0}, // R4
    '{4'd5, 3'd2, 8'hFF, 8'hFF, 8'h3F, 16'h0000, 22'h3FFFFF, 1'b0}, // R5
    '{4'd2, 3'd0, 8'h00, 8'h00, 8'h00, 16'h0000, 22'h000000, 1'b0}, // R2 wrap
    '{4'd5, 3'd2, 8'hFF, 8'hFE, 8'h3F, 16'h0000, 22'h3FFFFE, 1'b0}, // R5
    '{4'd8, 3'd4, 8'h00, 8'h00, 8'h00, 16'h0000, 22'h3FFFFE, 1'b1}, // R8
    '{4'd8, 3'd5, 8'h00, 8'h00, 8'h00, 16'h0000, 22'h000000, 1'b0}  // R8 wrap by two
  };

  task automatic check(input string tag, input logic [21:0] exp_pc, input logic exp_w);
    checks++;
    if (pc !== exp_pc || fetch_wide !== exp_w) begin
      errors++;
      $display("FAIL %s: pc=%h fetch_wide=%b expected pc=%h fetch_wide=%b",
               tag, pc, fetch_wide, exp_pc, exp_w);
    end
  endtask

  task automatic drive(input logic s, input logic [2:0] k, input logic [7:0] h,
                       input logic [7:0] l, input logic [7:0] e, input logic [15:0] im);
    @(negedge clk);
    step = s; jmp_kind = k; ptr_hi = h; ptr_lo = l; ext_reg = e; imm_word = im;
    @(posedge clk);
    #1;
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1;
    check("R1", 22'h0, 1'b0);
    @(negedge clk);
    rst = 1'b0;

    for (int i = 0; i < NV; i++) begin
      drive(1'b1, VECS[i].kind, VECS[i].hi, VECS[i].lo, VECS[i].ext, VECS[i].imm);
      check($sformatf("R%0d vec %0d", VECS[i].req, i), VECS[i].exp_pc, VECS[i].exp_w);
    end

    // R3: stalls with a live indirect jump on the inputs
    for (int i = 0; i < 3; i++) begin
      drive(1'b0, 3'd1, 8'h55, 8'h66, 8'h00, 16'h0000);
      check("R3 stall", 22'h000000, 1'b0);
    end

    // R6 then R9: stalls while the second word is pending
    drive(1'b1, 3'd3, 8'h00, 8'h00, 8'h00, 16'h0001);
    check("R6 abs first", 22'h000000, 1'b1);
    for (int i = 0; i < 2; i++) begin
      drive(1'b0, 3'd0, 8'h00, 8'h00, 8'h00, 16'hBEEF);
      check("R9 pending stall", 22'h000000, 1'b1);
    end
    drive(1'b1, 3'd2, 8'h77, 8'h77, 8'h3F, 16'h8000);
    check("R7 abs second", 22'h018000, 1'b0);

    // R1: reset in the middle of a pending two-word instruction
    drive(1'b1, 3'd4, 8'h00, 8'h00, 8'h00, 16'h0000);
    check("R8 first", 22'h018000, 1'b1);
    @(negedge clk);
    rst = 1'b1; step = 1'b0;
    @(posedge clk);
    #1;
    check("R1 mid-instruction", 22'h000000, 1'b0);
    @(negedge clk);
    rst = 1'b0;
    drive(1'b1, 3'd0, 8'h00, 8'h00, 8'h00, 16'h0000);
    check("R2 after reset", 22'h000001, 1'b0);

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: run did not complete, expected completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule